// File: doc/BRIEF.md
# Transmit-Side CPU Injection Header Inserter

This block sits on the byte-wide transmit stream that carries frames from a host CPU towards a switch. Ahead of every frame it places a 4-byte short prefix (0x88, 0x80, 0x00, 0x0A) and a 16-byte injection header. The frame bytes then follow unchanged. The header begins as a per-port 128-bit template that is supplied on a configuration input. Two groups of fields are overwritten for each frame: the 3-bit QoS class, and, for frames that ask for a transmit timestamp, a 9-bit rewriter operation.

The rewriter operation normally equals the configured PTP command. When that command equals the two-step code set by a parameter, the frame's timestamp identifier is shifted left by three and ORed into the command, and the result is cut to 9 bits. The per-frame sideband is captured in the cycle that a new frame's first byte is first offered. The block holds input ready low while it sends the 20 inserted bytes. After that, input ready follows output ready, and the end-of-packet flag passes through with the frame.

Top module: `cpu_inj_hdr_tx`

## Requirements
- R1: Out of reset, mValid and sReady are both low until a frame's first byte is offered.
- R2: Every output frame is the bytes 0x88, 0x80, 0x00, 0x0A, then 16 header bytes, then every input frame byte in order and unmodified.
- R3: Header bits go out most significant first: bits 127:120 form header byte 0 and bits 7:0 form header byte 15. All template bits not named in R4 to R6 are sent unchanged. This includes bit 127 and the destination field below bit 68.
- R4: Header bits 19:17 carry the frame's QoS class, whatever the template holds there.
- R5: When tsReq is high, header bits 125:117 carry the rewriter operation. For a non-two-step command this equals ptpCmd.
- R6: When ptpCmd equals the two-step code (default 3), the rewriter operation is (ptpCmd OR (tsId << 3)) truncated to 9 bits.
- R7: When tsReq is low, header bits 125:117 are the template's own bits.
- R8: sReady stays low while any of a frame's 20 inserted bytes is still unsent.
- R9: mLast is high only on the final frame byte, and never on an inserted byte.
- R10: While mValid is high and mReady is low, mValid stays high and mData stays unchanged on the next cycle.
- R11: Sideband (qos, tsReq, tsId) is captured when the first byte is offered. Later changes during the same frame have no effect on its header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmplHdr | input | 128 | Per-port header template |
| ptpCmd | input | 9 | Configured PTP rewriter command |
| qos | input | 3 | Per-frame QoS class |
| tsReq | input | 1 | Per-frame transmit timestamp request |
| tsId | input | 6 | Per-frame timestamp identifier |
| sData | input | 8 | Input frame byte |
| sValid | input | 1 | Input byte valid |
| sLast | input | 1 | Input byte is the frame's last |
| sReady | output | 1 | Input byte accepted when high with sValid |
| mData | output | 8 | Output byte |
| mValid | output | 1 | Output byte valid |
| mLast | output | 1 | Output byte is the frame's last |
| mReady | input | 1 | Downstream ready |

## Verification
Suppose the byte counter or the phase state goes wrong. The first sign is a shifted or missing prefix byte, or sReady rising before the twentieth inserted byte has left. Either shows up within the same frame, at the first accepted beat that is off. Suppose the header image is loaded from the wrong sideband, or patched at the wrong bit positions. Then exactly one or two header bytes are wrong: index 4 or 5 for the rewriter field, and index 17 for the QoS class. The per-byte comparison catches this before the frame body starts. Stall cases are covered as well: each cycle in which output ready is low confirms that the pending byte holds steady.

// File: rtl/cpu_inj_hdr_pkg.sv
`timescale 1ns/1ps
package cpu_inj_hdr_pkg;
  localparam int PFX_BYTES = 4;
  localparam int HDR_BYTES = 16;
  localparam int INS_BYTES = PFX_BYTES + HDR_BYTES;
  localparam int CNT_W     = $clog2(INS_BYTES);
  localparam logic [8*PFX_BYTES-1:0] SHORT_PFX = 32'h8880_000A;

  typedef enum logic [1:0] {ST_IDLE, ST_INSERT, ST_BODY} phase_t;

  typedef struct packed {
    logic load;   // capture sideband and build the insert image
    logic shift;  // one inserted byte was taken downstream
    logic pass;   // frame body flows through
    logic ins;    // an inserted byte is on the output
  } ctrlStrb_t;
endpackage

// File: rtl/cpu_inj_hdr_ctrl.sv
`timescale 1ns/1ps
module cpu_inj_hdr_ctrl
  import cpu_inj_hdr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sValid,
  input  logic      sLast,
  input  logic      mReady,
  output ctrlStrb_t strb
);
  phase_t            phase;
  logic [CNT_W-1:0]  insCnt;

  always_comb begin
    strb.load  = (phase == ST_IDLE) && sValid;
    strb.ins   = (phase == ST_INSERT);
    strb.shift = (phase == ST_INSERT) && mReady;
    strb.pass  = (phase == ST_BODY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= ST_IDLE;
      insCnt <= '0;
    end else begin
      unique case (phase)
        ST_IDLE: if (sValid) begin
          phase  <= ST_INSERT;
          insCnt <= '0;
        end
        ST_INSERT: if (mReady) begin
          if (insCnt == CNT_W'(INS_BYTES - 1)) phase <= ST_BODY;
          else                                  insCnt <= insCnt + 1'b1;
        end
        ST_BODY: if (sValid && mReady && sLast) phase <= ST_IDLE;
        default: phase <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpu_inj_hdr_dp.sv
`timescale 1ns/1ps
module cpu_inj_hdr_dp
  import cpu_inj_hdr_pkg::*;
#(
  parameter int          TS_ID_W      = 6,
  parameter int          REW_W        = 9,
  parameter logic [8:0]  TWO_STEP_CMD = 9'd3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [127:0]       tmplHdr,
  input  logic [REW_W-1:0]   ptpCmd,
  input  logic [2:0]         qos,
  input  logic               tsReq,
  input  logic [TS_ID_W-1:0] tsId,
  input  logic [7:0]         sData,
  input  logic               sValid,
  input  logic               sLast,
  input  logic               mReady,
  output logic [7:0]         mData,
  output logic               mValid,
  output logic               mLast,
  output logic               sReady
);
  localparam int MRG_W = (TS_ID_W + 3 > REW_W) ? TS_ID_W + 3 : REW_W;
  localparam int IMG_W = 8 * INS_BYTES;

  logic [MRG_W-1:0] merged;
  logic [REW_W-1:0] rewOp;
  logic [127:0]     hdrImg;
  logic [IMG_W-1:0] insImg;

  always_comb begin
    merged = MRG_W'(ptpCmd) | (MRG_W'(tsId) << 3);
    rewOp  = (ptpCmd == REW_W'(TWO_STEP_CMD)) ? merged[REW_W-1:0] : ptpCmd;
    hdrImg = tmplHdr;
    hdrImg[19:17] = qos;
    if (tsReq) hdrImg[125:117] = rewOp[8:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           insImg <= '0;
    else if (strb.load)  insImg <= {SHORT_PFX, hdrImg};
    else if (strb.shift) insImg <= insImg << 8;
  end

  always_comb begin
    mData  = strb.pass ? sData  : insImg[IMG_W-1 -: 8];
    mValid = strb.pass ? sValid : strb.ins;
    mLast  = strb.pass && sLast;
    sReady = strb.pass && mReady;
  end
endmodule

// File: rtl/cpu_inj_hdr_tx.sv
`timescale 1ns/1ps
module cpu_inj_hdr_tx
  import cpu_inj_hdr_pkg::*;
#(
  parameter int          TS_ID_W      = 6,
  parameter logic [8:0]  TWO_STEP_CMD = 9'd3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [127:0]       tmplHdr,
  input  logic [8:0]         ptpCmd,
  input  logic [2:0]         qos,
  input  logic               tsReq,
  input  logic [TS_ID_W-1:0] tsId,
  input  logic [7:0]         sData,
  input  logic               sValid,
  input  logic               sLast,
  output logic               sReady,
  output logic [7:0]         mData,
  output logic               mValid,
  output logic               mLast,
  input  logic               mReady
);
  ctrlStrb_t strb;

  cpu_inj_hdr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sValid(sValid), .sLast(sLast),
    .mReady(mReady), .strb(strb)
  );

  cpu_inj_hdr_dp #(.TS_ID_W(TS_ID_W), .REW_W(9), .TWO_STEP_CMD(TWO_STEP_CMD)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tmplHdr(tmplHdr), .ptpCmd(ptpCmd),
    .qos(qos), .tsReq(tsReq), .tsId(tsId), .sData(sData), .sValid(sValid),
    .sLast(sLast), .mReady(mReady), .mData(mData), .mValid(mValid),
    .mLast(mLast), .sReady(sReady)
  );
endmodule

// File: rtl/cpu_inj_hdr_chk.sv
`timescale 1ns/1ps
module cpu_inj_hdr_chk #(
  parameter int TS_ID_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic [127:0]       tmplHdr,
  input logic [8:0]         ptpCmd,
  input logic [2:0]         qos,
  input logic               tsReq,
  input logic [TS_ID_W-1:0] tsId,
  input logic [7:0]         sData,
  input logic               sValid,
  input logic               sLast,
  input logic               sReady,
  input logic [7:0]         mData,
  input logic               mValid,
  input logic               mLast,
  input logic               mReady
);
  logic [4:0] outCnt;

  always_ff @(posedge clk) begin
    if (!rstN) outCnt <= '0;
    else if (mValid && mReady) begin
      if (mLast)             outCnt <= '0;
      else if (outCnt < 5'd20) outCnt <= outCnt + 1'b1;
    end
  end

  // R8
  ins_hold_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outCnt < 5'd20) |-> !sReady);

  // R2
  pfx_first_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && outCnt == 5'd0) |-> (mData == 8'h88));

  // R9
  last_in_body_chk: assert property (@(posedge clk) disable iff (!rstN)
    mLast |-> (outCnt == 5'd20 && sLast && mValid));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mValid && !mReady) |=> (mValid && $stable(mData)));
endmodule

bind cpu_inj_hdr_tx cpu_inj_hdr_chk #(.TS_ID_W(TS_ID_W)) u_chk (.*);

// File: tb/sim_cpu_inj_hdr_tx.sv
`timescale 1ns/1ps
module sim_cpu_inj_hdr_tx;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [127:0] tmplHdr = '0;
  logic [8:0]   ptpCmd = '0;
  logic [2:0]   qos = '0;
  logic         tsReq = 1'b0;
  logic [5:0]   tsId = '0;
  logic [7:0]   sData = '0;
  logic         sValid = 1'b0;
  logic         sLast = 1'b0;
  logic         sReady;
  logic [7:0]   mData;
  logic         mValid;
  logic         mLast;
  logic         mReady = 1'b1;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int outIdx = 0;
  bit stallMode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit   prevStall = 1'b0;
  logic [7:0] prevData = '0;

  logic [7:0] expD[$];
  bit         expL[$];
  string      expT[$];

  always #2.5 clk = ~clk;

  cpu_inj_hdr_tx u0 (
    .clk(clk), .rstN(rstN), .tmplHdr(tmplHdr), .ptpCmd(ptpCmd), .qos(qos),
    .tsReq(tsReq), .tsId(tsId), .sData(sData), .sValid(sValid), .sLast(sLast),
    .sReady(sReady), .mData(mData), .mValid(mValid), .mLast(mLast), .mReady(mReady)
  );

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // downstream readiness
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mReady <= stallMode ? (lfsr[0] | lfsr[3]) : 1'b1;
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual run still going, expected finish");
      finishRun();
    end
  end

  // reference comparison, sampled between edges
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      // R10: a stalled byte must stay put
      if (prevStall) begin
        compared = compared + 1;
        if (!mValid || mData !== prevData) begin
          mismatched = mismatched + 1;
          $display("FAIL R10 stall: actual valid=%0b data=%h expected valid=1 data=%h",
                   mValid, mData, prevData);
        end
      end
      prevStall = mValid && !mReady;
      prevData  = mData;
      // R8: no input taken during the inserted bytes
      if (outIdx < 20 && sReady) begin
        compared = compared + 1;
        mismatched = mismatched + 1;
        $display("FAIL R8 ready early: actual sReady=1 at out byte %0d expected 0", outIdx);
      end
      if (mValid && mReady) begin
        compared = compared + 1;
        if (expD.size() == 0) begin
          mismatched = mismatched + 1;
          $display("FAIL R2 extra byte: actual %h expected none", mData);
        end else begin
          logic [7:0] d;
          bit l;
          string t;
          d = expD.pop_front(); l = expL.pop_front(); t = expT.pop_front();
          if (mData !== d || mLast !== l) begin
            mismatched = mismatched + 1;
            $display("FAIL %s byte %0d: actual %h last=%0b expected %h last=%0b",
                     t, outIdx, mData, mLast, d, l);
          end
        end
        outIdx = mLast ? 0 : outIdx + 1;
      end
    end
  end

  task automatic sendFrame(input logic [127:0] t, input logic [8:0] cmd,
                           input logic [2:0] q, input bit ts, input logic [5:0] id,
                           input int len, input logic [7:0] seed);
    logic [127:0] h;
    logic [8:0]   op;
    logic [159:0] img;
    h = t;
    h[19:17] = q;                               // R4
    if (ts) begin
      op = cmd;                                  // R5
      if (cmd == 9'd3) op = cmd | 9'(({3'b000, id}) << 3);  // R6
      h[125:117] = op;
    end                                          // R7: otherwise template kept
    img = {32'h8880_000A, h};
    for (int i = 0; i < 20; i++) begin
      expD.push_back(img[159 - 8*i -: 8]);
      expL.push_back(1'b0);
      if (i < 4)                 expT.push_back("R2 prefix");
      else if (i == 4 || i == 5) expT.push_back("R5 R6 R7 R11 rewriter");
      else if (i == 17)          expT.push_back("R4 R11 qos");
      else                       expT.push_back("R3 template");
    end
    for (int i = 0; i < len; i++) begin
      expD.push_back(8'(seed + i));
      expL.push_back(i == len - 1);
      expT.push_back(i == len - 1 ? "R9 last body" : "R2 body");
    end
    @(negedge clk);
    tmplHdr = t; ptpCmd = cmd; qos = q; tsReq = ts; tsId = id;
    for (int i = 0; i < len; i++) begin
      sValid = 1'b1; sData = 8'(seed + i); sLast = (i == len - 1);
      if (i == 0) begin
        @(posedge clk);
        @(negedge clk);
        // R11: sideband scrambled after capture
        qos = ~q; tsReq = ~ts; tsId = ~id;
      end
      forever begin
        #0.5;
        if (sReady) begin
          @(posedge clk);
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    sValid = 1'b0; sLast = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1
    compared = compared + 1;
    if (mValid !== 1'b0 || sReady !== 1'b0) begin
      mismatched = mismatched + 1;
      $display("FAIL R1 reset: actual mValid=%0b sReady=%0b expected 0 0", mValid, sReady);
    end
    repeat (2) @(negedge clk);
    compared = compared + 1;
    if (mValid !== 1'b0) begin
      mismatched = mismatched + 1;
      $display("FAIL R1 idle: actual mValid=%0b expected 0", mValid);
    end
    // R3 R4 R7: distinct template, no timestamp
    sendFrame(128'h8123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978, 9'd1, 3'd5, 1'b0, 6'd9, 6, 8'h10);
    // R5: timestamp, one-step command
    sendFrame(128'h0000_0000_0000_0000_0000_0000_0000_0000, 9'd2, 3'd0, 1'b1, 6'h2A, 1, 8'h40);
    // R6: two-step merge with all-ones id, truncated result 0x1FB
    sendFrame(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 9'd3, 3'd0, 1'b1, 6'h3F, 3, 8'h70);
    // R6: two-step merge with a sparse id
    sendFrame(128'h5A5A_5A5A_5A5A_5A5A_5A5A_5A5A_5A5A_5A5A, 9'd3, 3'd2, 1'b1, 6'h05, 4, 8'hE0);
    // R10: downstream stalls
    stallMode = 1'b1;
    sendFrame(128'hDEAD_BEEF_0123_4567_0000_00F8_1234_FFFF, 9'd3, 3'd7, 1'b1, 6'h11, 9, 8'h00);
    sendFrame(128'h0F0F_0F0F_F0F0_F0F0_AAAA_5555_3333_CCCC, 9'd4, 3'd1, 1'b0, 6'h01, 2, 8'hA0);
    sendFrame(128'h7FFF_0000_FFFF_0000_1111_2222_3333_4444, 9'd6, 3'd4, 1'b1, 6'h3E, 5, 8'h55);
    stallMode = 1'b0;
    repeat (40) @(negedge clk);
    compared = compared + 1;
    if (expD.size() != 0) begin
      mismatched = mismatched + 1;
      $display("FAIL R2 missing bytes: actual %0d left expected 0", expD.size());
    end
    finishRun();
  end
endmodule